// File: doc/BRIEF.md
# Burst-of-Four Quad-Data-Rate Memory Core

This block is a synthesizable behavioural model of a quad-data-rate static memory core. It has a read data port and a write data port that share one address bus. Every address names one wide word made of four narrow beats. A read streams those four beats out, and a write collects four beats before it updates the array. Both ports can run bursts at the same time. With well-scheduled requests, each port moves one beat on every edge of the beat clock.

The core runs from a single clock at the beat rate. An internal phase bit alternates between "K" edges and "K#" edges. The phase bit is brought out so that the controller knows which edge comes next. Requests are taken only on K edges. A port cannot start bursts on two K edges in a row. When both ports ask on the same K edge, the kind of burst started on the previous K edge decides which port wins. A read of an address whose write burst is still being collected returns the newest bytes. An output-enable flag stands in for the tristate drivers of a real pad ring.

Top module: `qdr_burst_core`

## Requirements
- R1: After reset, `rdata_oe` is 0 and `k_rise` is 1, so the first clock edge after reset is a K edge.
- R2: Beat k of a burst is bits [18k+17:18k] of the 72-bit word. Beats leave and arrive in the order k = 0, 1, 2, 3.
- R3: A read accepted at K edge E drives beat 0 with `rdata_oe` = 1 after edge E+2, and beats 1..3 after edges E+3..E+5.
- R4: A write accepted at K edge E samples `wdata` at edges E+2..E+5. A later read sees the full word.
- R5: Each write beat has its own mask. When `wbyte_n[0]` is 0 the beat writes bits 8:0, and when `wbyte_n[1]` is 0 it writes bits 17:9. A byte whose mask bit is 1 keeps its stored value.
- R6: A select that is asserted on the K edge right after that same port started a burst is ignored. A new burst from that port can start every second K edge.
- R7: Only one burst starts per K edge. With both selects low, the read wins if the previous K edge started nothing or started a write, and the write wins if the previous K edge started a read. Holding both selects low from idle therefore gives read, write, read, write.
- R8: A read returns the newest data, including bytes from a write that started on the previous K edge and has not yet been committed. The merge is per byte and per beat, using that write's masks.
- R9: When no new read follows, `rdata_oe` falls after the edge that follows the last beat. Reads started every second K edge keep `rdata_oe` high without gaps.
- R10: Selects that are low only on K# edges start nothing. Reads, writes and outputs are unaffected.
- R11: `k_rise` toggles on every clock edge after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat-rate clock; edges alternate between K and K# |
| rst_n | input | 1 | Asynchronous active-low reset |
| k_rise | output | 1 | 1 when the coming clock edge is a K edge |
| rd_sel_n | input | 1 | Active-low read request, sampled on K edges |
| wr_sel_n | input | 1 | Active-low write request, sampled on K edges |
| addr | input | AW | Shared word address |
| wdata | input | BEAT_W | Write beat |
| wbyte_n | input | 2 | Active-low byte masks for the current write beat |
| rdata | output | BEAT_W | Read beat |
| rdata_oe | output | 1 | Read beat valid / output drive enable |

## Verification
The bench builds the core with `AW` = 4 and the default 18-bit beat, which gives a 16-word array. Because the array is this small, every word can be filled before checking begins. Random traffic with both selects active then lands on the address of an in-flight write often, so forwarding, byte merging and the arbitration history are all exercised heavily. Directed phases cover masked beats, selects held low across consecutive K edges, selects driven low only on K# edges, and read streams that stop or continue back to back.

// File: rtl/qdr_burst_core.sv
module qdr_burst_core #(
  parameter int AW     = 8,
  parameter int BEAT_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              k_rise,
  input  logic              rd_sel_n,
  input  logic              wr_sel_n,
  input  logic [AW-1:0]     addr,
  input  logic [BEAT_W-1:0] wdata,
  input  logic [1:0]        wbyte_n,
  output logic [BEAT_W-1:0] rdata,
  output logic              rdata_oe
);
  localparam int BYTE_W = BEAT_W / 2;
  localparam int WORD_W = 4 * BEAT_W;
  localparam int DEPTH  = 1 << AW;

  logic [WORD_W-1:0] mem [DEPTH];

  logic              prev_rd, prev_wr;
  logic              rpend, rrun, wpend, wrun;
  logic [1:0]        rbeat, wbeat;
  logic [AW-1:0]     rpaddr, raddr, wpaddr, waddr;
  logic [BEAT_W-1:0] wbuf [4];
  logic [1:0]        wbm  [4];

  logic rd_acc, wr_acc;
  assign rd_acc = k_rise && !rd_sel_n && !prev_rd;
  assign wr_acc = k_rise && !wr_sel_n && !prev_wr && !rd_acc;

  logic          rd_first, rd_go, wr_first, wr_cap, commit;
  logic [1:0]    rd_k, wr_k;
  logic [AW-1:0] rd_a;
  assign rd_first = rpend && k_rise;
  assign rd_go    = rd_first || rrun;
  assign rd_k     = rd_first ? 2'd0 : rbeat;
  assign rd_a     = rd_first ? rpaddr : raddr;
  assign wr_first = wpend && k_rise;
  assign wr_cap   = wr_first || wrun;
  assign wr_k     = wr_first ? 2'd0 : wbeat;
  assign commit   = wrun && (wbeat == 2'd3);

  logic [WORD_W-1:0] rd_word, cm_word;
  logic [BEAT_W-1:0] rd_val;

  always_comb begin
    rd_word = mem[rd_a];
    rd_val  = rd_word[rd_k*BEAT_W +: BEAT_W];
    for (int b = 0; b < 2; b++)
      if (wrun && (waddr == rd_a) && wbm[rd_k][b])
        rd_val[b*BYTE_W +: BYTE_W] = wbuf[rd_k][b*BYTE_W +: BYTE_W];
  end

  always_comb begin
    cm_word = mem[waddr];
    for (int k = 0; k < 4; k++)
      for (int b = 0; b < 2; b++)
        if (k == 3) begin
          if (!wbyte_n[b]) cm_word[k*BEAT_W + b*BYTE_W +: BYTE_W] = wdata[b*BYTE_W +: BYTE_W];
        end else if (wbm[k][b]) begin
          cm_word[k*BEAT_W + b*BYTE_W +: BYTE_W] = wbuf[k][b*BYTE_W +: BYTE_W];
        end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      k_rise   <= 1'b1;
      prev_rd  <= 1'b0;
      prev_wr  <= 1'b0;
      rpend    <= 1'b0;
      rrun     <= 1'b0;
      rbeat    <= 2'd0;
      rpaddr   <= '0;
      raddr    <= '0;
      wpend    <= 1'b0;
      wrun     <= 1'b0;
      wbeat    <= 2'd0;
      wpaddr   <= '0;
      waddr    <= '0;
      rdata    <= '0;
      rdata_oe <= 1'b0;
      for (int k = 0; k < 4; k++) wbm[k] <= 2'b00;
    end else begin
      k_rise <= !k_rise;
      if (k_rise) begin
        prev_rd <= rd_acc;
        prev_wr <= wr_acc;
      end

      rdata_oe <= rd_go;
      rdata    <= rd_go ? rd_val : '0;
      if (rd_first) begin
        rpend <= 1'b0;
        raddr <= rpaddr;
        rrun  <= 1'b1;
        rbeat <= 2'd1;
      end else if (rrun) begin
        rbeat <= rbeat + 2'd1;
        if (rbeat == 2'd3) rrun <= 1'b0;
      end
      if (rd_acc) begin
        rpend  <= 1'b1;
        rpaddr <= addr;
      end

      if (wr_first) begin
        wpend  <= 1'b0;
        waddr  <= wpaddr;
        wrun   <= 1'b1;
        wbeat  <= 2'd1;
        wbm[0] <= ~wbyte_n;
        wbm[1] <= 2'b00;
        wbm[2] <= 2'b00;
        wbm[3] <= 2'b00;
      end else if (wrun) begin
        wbm[wbeat] <= ~wbyte_n;
        wbeat      <= wbeat + 2'd1;
        if (wbeat == 2'd3) wrun <= 1'b0;
      end
      if (wr_acc) begin
        wpend  <= 1'b1;
        wpaddr <= addr;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_cap) wbuf[wr_k] <= wdata;
    if (commit) mem[waddr] <= cm_word;
  end

  assert_oe_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdata_oe) |-> !k_rise);

  assert_k_toggle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (k_rise != $past(k_rise)));

  assert_oe_span_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdata_oe) |-> $past(rdata_oe, 4));

  assert_rd_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rpend |-> !rd_acc);

  assert_wr_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wpend |-> !wr_acc);

  assert_one_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(rpend && wpend));
endmodule

// File: tb/qdr_burst_core_tb.sv
module qdr_burst_core_tb;
  localparam int AW = 4;
  localparam int BW = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          rs_n = 1'b1, ws_n = 1'b1;
  logic [AW-1:0] a = '0;
  logic [BW-1:0] d = '0;
  logic [1:0]    bwn = 2'b11;
  logic          k_rise, oe;
  logic [BW-1:0] q;

  qdr_burst_core #(.AW(AW), .BEAT_W(BW)) u_dut (
    .clk(clk), .rst_n(rst_n), .k_rise(k_rise),
    .rd_sel_n(rs_n), .wr_sel_n(ws_n), .addr(a),
    .wdata(d), .wbyte_n(bwn), .rdata(q), .rdata_oe(oe));

  int    checks = 0, bad = 0;
  string tag = "R1";
  bit    done = 0;

  typedef struct packed { logic [31:0] e; logic [31:0] ad; logic [31:0] k; } ev_t;
  ev_t rq[$];
  ev_t wq[$];
  logic [71:0] mm [int];

  logic c_rs = 1, c_ws = 1, c_rst = 0;
  logic [AW-1:0] c_a = '0;
  logic [BW-1:0] c_d = '0;
  logic [1:0]    c_bw = 2'b11;
  always @(posedge clk) begin
    c_rs <= rs_n; c_ws <= ws_n; c_a <= a; c_d <= d; c_bw <= bwn; c_rst <= rst_n;
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  int   n = 0;
  bit   mk = 1, mprd = 0, mpwr = 0, ra, wa;
  logic eo;
  logic [BW-1:0] eq;
  logic [71:0] tmp;
  ev_t ev;

  always @(negedge clk) begin
    if (c_rst && !done) begin
      eo = 0; eq = '0;
      if (rq.size() > 0 && rq[0].e == n) begin
        ev = rq.pop_front();
        tmp = mm[int'(ev.ad)];
        eo = 1; eq = tmp[ev.k*18 +: 18];
      end
      if (wq.size() > 0 && wq[0].e == n) begin
        ev = wq.pop_front();
        tmp = mm[int'(ev.ad)];
        if (!c_bw[0]) tmp[ev.k*18 +: 9] = c_d[8:0];
        if (!c_bw[1]) tmp[ev.k*18 + 9 +: 9] = c_d[17:9];
        mm[int'(ev.ad)] = tmp;
      end
      if (mk) begin
        ra = !c_rs && !mprd;
        wa = !c_ws && !mpwr && !ra;
        for (int k = 0; k < 4; k++) begin
          if (ra) rq.push_back({32'(n + 2 + k), 32'(c_a), 32'(k)});
          if (wa) wq.push_back({32'(n + 2 + k), 32'(c_a), 32'(k)});
        end
        mprd = ra; mpwr = wa;
      end
      mk = !mk;
      n++;
      chk({tag, " oe"}, 32'(oe), 32'(eo));
      if (eo) chk({tag, " data"}, 32'(q), 32'(eq));
      chk("R11 phase", 32'(k_rise), 32'(mk));
    end
  end

  task automatic drive(input logic r, input logic w, input logic [AW-1:0] aa,
                       input logic [BW-1:0] dd, input logic [1:0] bb);
    rs_n = r; ws_n = w; a = aa; d = dd; bwn = bb;
    @(negedge clk);
  endtask

  task automatic idle();
    drive(1, 1, '0, BW'($urandom()), 2'b11);
  endtask

  task automatic align();
    while (!k_rise) idle();
  endtask

  task automatic wr_burst(input logic [AW-1:0] aa, input logic [71:0] w, input logic [7:0] m);
    align();
    drive(1, 0, aa, BW'($urandom()), 2'b11);
    idle();
    for (int k = 0; k < 4; k++) drive(1, 1, '0, w[k*18 +: 18], m[2*k +: 2]);
  endtask

  task automatic rd_burst(input logic [AW-1:0] aa);
    align();
    drive(0, 1, aa, BW'($urandom()), 2'b11);
    repeat (5) idle();
  endtask

  function automatic logic [71:0] rnd72();
    return {8'($urandom()), 32'($urandom()), 32'($urandom())};
  endfunction

  task automatic finish_run();
    done = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 oe", 32'(oe), 32'd0);
    chk("R1 phase", 32'(k_rise), 32'd1);
    rst_n = 1'b1;

    tag = "R4";
    for (int i = 0; i < 16; i++) wr_burst(AW'(i), rnd72(), 8'h00);

    tag = "R2 R3";
    for (int i = 0; i < 16; i++) rd_burst(AW'(i));

    tag = "R5";
    wr_burst(4'd3, rnd72(), 8'b11_01_10_00);
    rd_burst(4'd3);
    wr_burst(4'd3, rnd72(), 8'b00_10_01_11);
    rd_burst(4'd3);
    wr_burst(4'd9, rnd72(), 8'hFF);
    rd_burst(4'd9);

    tag = "R6";
    align();
    for (int i = 0; i < 12; i++) drive(0, 1, AW'(i), BW'($urandom()), 2'b11);
    repeat (6) idle();
    align();
    for (int i = 0; i < 12; i++) drive(1, 0, AW'(i + 2), BW'($urandom()), 2'(i));
    repeat (6) idle();
    for (int i = 0; i < 4; i++) rd_burst(AW'(i + 2));

    tag = "R7";
    align();
    for (int i = 0; i < 24; i++) drive(0, 0, AW'($urandom()), BW'($urandom()), 2'($urandom()));
    repeat (6) idle();

    tag = "R8";
    align();
    drive(1, 0, 4'd5, BW'($urandom()), 2'b11);
    idle();
    drive(0, 1, 4'd5, BW'($urandom()), 2'b10);
    drive(1, 1, '0, BW'($urandom()), 2'b01);
    drive(1, 1, '0, BW'($urandom()), 2'b00);
    drive(1, 1, '0, BW'($urandom()), 2'b11);
    repeat (4) idle();
    align();
    drive(1, 0, 4'd6, BW'($urandom()), 2'b11);
    idle();
    drive(0, 1, 4'd6, BW'($urandom()), 2'b00);
    drive(1, 1, '0, BW'($urandom()), 2'b00);
    drive(1, 0, 4'd6, BW'($urandom()), 2'b00);
    drive(1, 1, '0, BW'($urandom()), 2'b00);
    for (int k = 0; k < 4; k++) drive(1, 1, '0, BW'($urandom()), 2'b01);
    repeat (4) idle();
    rd_burst(4'd6);

    tag = "R9";
    rd_burst(4'd1);
    align();
    for (int i = 0; i < 3; i++) begin
      drive(0, 1, AW'(i + 7), BW'($urandom()), 2'b11);
      repeat (3) idle();
    end
    repeat (6) idle();

    tag = "R10";
    for (int i = 0; i < 16; i++) begin
      if (k_rise) idle();
      else drive(0, 0, AW'(i), BW'($urandom()), 2'b00);
    end
    repeat (6) idle();
    for (int i = 0; i < 4; i++) rd_burst(AW'(i));

    tag = "R7 R8 random";
    for (int i = 0; i < 3000; i++)
      drive(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), AW'($urandom()),
            BW'($urandom()), 2'($urandom()));
    repeat (8) idle();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
    end
  end
endmodule